// File: doc/BRIEF.md
# Dropped Receive Frame Event Counter Word

This block keeps count of receive frames that had to be thrown away, sorted by cause, and presents both counts in one 32-bit read-only status word. One cause is a receive FIFO overflow at a moment when no host buffer was ready for the frame. The other is a FIFO overflow while a buffer was ready, because the receive DMA could not empty the FIFO fast enough. Each cause has its own saturating counter and its own sticky flag, which records that more events occurred than the counter can show.

Upstream logic pulses one single-cycle strobe per dropped frame. The bus decode pulses a read strobe in the cycle the word is returned to software. The word is sampled in that cycle, and everything in it clears at the next clock edge. An event that coincides with a read is kept: it is counted into the freshly cleared counter. Both counts and both flags are held in registers, and the read word is a direct concatenation of them.

Top module: `dfc_status_reg`

## Requirements
- R1: Word layout: bit 31 is the no-buffer overflow flag, bits 30:17 the 14-bit no-buffer count, bit 16 the slow-DMA overflow flag, bits 15:0 the 16-bit slow-DMA count.
- R2: Each cycle with `nobuf_ev_i` high and no read raises the no-buffer count by one, while the count is below its maximum.
- R3: Each cycle with `slowdma_ev_i` high and no read raises the slow-DMA count by one, while the count is below its maximum.
- R4: Both strobes high in the same cycle update both counters, each by its own rule.
- R5: In a cycle with `rd_i` high, `rd_data_o` shows the value from before that cycle's events. After the edge, every counter and flag with no coincident event reads zero.
- R6: A strobe in the same cycle as a read leaves its counter at 1 and its flag at 0.
- R7: A strobe that arrives while its counter is at its maximum (16383 or 65535) keeps the counter at its maximum and sets its flag.
- R8: Once set, a flag stays set until a read. A counter that reaches its maximum without a further event leaves its flag clear.
- R9: A synchronous active-high `rst` clears both counters and both flags.
- R10: In a cycle with no strobe and no read, the word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nobuf_ev_i | input | 1 | One-cycle pulse: frame dropped on FIFO overflow with no host buffer ready |
| slowdma_ev_i | input | 1 | One-cycle pulse: frame dropped on FIFO overflow because the DMA fell behind |
| rd_i | input | 1 | One-cycle pulse: the word is read in this cycle and clears afterwards |
| rd_data_o | output | 32 | Packed status word (flags and counts) |

## Verification
Every strobe and every read takes effect at the first rising edge that samples it. The word therefore shows the result one cycle after the stimulus, and during a read cycle it still shows the value from before that edge. The bench drives inputs on the falling edge and reads `rd_data_o` on the next falling edge, half a period after the edge that updated it. For read rows it also checks the word before that edge, so both the value returned and the value left behind are checked. The saturation runs step each counter through every value to its maximum, then check the word at the maximum and one event beyond it.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

  // Default field widths of the status word.
  localparam int unsigned NOBUF_CNT_W   = 14;
  localparam int unsigned SLOWDMA_CNT_W = 16;

  // Width of one counter plus its sticky flag.
  function automatic int unsigned field_w(input int unsigned cnt_w);
    return cnt_w + 1;
  endfunction

endpackage

// File: rtl/dfc_sat_counter.sv
module dfc_sat_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             more_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             more_q;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      more_q <= 1'b0;
    end else if (clr_i) begin
      // The value before this edge has been read. A coincident event
      // starts the new count.
      cnt_q  <= inc_i ? CNT_ONE : '0;
      more_q <= 1'b0;
    end else if (inc_i) begin
      if (at_max) begin
        more_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_ONE;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign more_o = more_q;

endmodule

// File: rtl/dfc_word_pack.sv
module dfc_word_pack #(
  parameter int unsigned HI_W = 14,
  parameter int unsigned LO_W = 16,
  localparam int unsigned WORD_W = HI_W + LO_W + 2
) (
  input  logic              hi_more_i,
  input  logic [HI_W-1:0]   hi_cnt_i,
  input  logic              lo_more_i,
  input  logic [LO_W-1:0]   lo_cnt_i,
  output logic [WORD_W-1:0] word_o
);

  // Flag above its count, upper field above lower field.
  assign word_o = {hi_more_i, hi_cnt_i, lo_more_i, lo_cnt_i};

endmodule

// File: rtl/dfc_status_reg.sv
module dfc_status_reg #(
  parameter int unsigned NB_W = dfc_pkg::NOBUF_CNT_W,
  parameter int unsigned SD_W = dfc_pkg::SLOWDMA_CNT_W,
  localparam int unsigned WORD_W = dfc_pkg::field_w(NB_W) + dfc_pkg::field_w(SD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nobuf_ev_i,
  input  logic              slowdma_ev_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rd_data_o
);

  logic [NB_W-1:0] nb_cnt;
  logic            nb_more;
  logic [SD_W-1:0] sd_cnt;
  logic            sd_more;

  dfc_sat_counter #(.CNT_W(NB_W)) u_nobuf_cnt (
    .clk    (clk),
    .rst    (rst),
    .inc_i  (nobuf_ev_i),
    .clr_i  (rd_i),
    .cnt_o  (nb_cnt),
    .more_o (nb_more)
  );

  dfc_sat_counter #(.CNT_W(SD_W)) u_slowdma_cnt (
    .clk    (clk),
    .rst    (rst),
    .inc_i  (slowdma_ev_i),
    .clr_i  (rd_i),
    .cnt_o  (sd_cnt),
    .more_o (sd_more)
  );

  dfc_word_pack #(.HI_W(NB_W), .LO_W(SD_W)) u_pack (
    .hi_more_i (nb_more),
    .hi_cnt_i  (nb_cnt),
    .lo_more_i (sd_more),
    .lo_cnt_i  (sd_cnt),
    .word_o    (rd_data_o)
  );

endmodule

// File: rtl/dfc_status_reg_chk.sv
module dfc_status_reg_chk #(
  parameter int unsigned NB_W = 14,
  parameter int unsigned SD_W = 16,
  localparam int unsigned WORD_W = NB_W + SD_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              nobuf_ev_i,
  input logic              slowdma_ev_i,
  input logic              rd_i,
  input logic [WORD_W-1:0] rd_data_o
);

  localparam logic [NB_W-1:0] NB_MAX = {NB_W{1'b1}};
  localparam logic [SD_W-1:0] SD_MAX = {SD_W{1'b1}};

  logic [NB_W-1:0] nb_cnt;
  logic            nb_flag;
  logic [SD_W-1:0] sd_cnt;
  logic            sd_flag;

  assign nb_flag = rd_data_o[WORD_W-1];
  assign nb_cnt  = rd_data_o[WORD_W-2 -: NB_W];
  assign sd_flag = rd_data_o[SD_W];
  assign sd_cnt  = rd_data_o[SD_W-1:0];

  // R5
  nb_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !nobuf_ev_i) |=> (nb_cnt == '0 && !nb_flag));

  // R5
  sd_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !slowdma_ev_i) |=> (sd_cnt == '0 && !sd_flag));

  // R6
  nb_read_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && nobuf_ev_i) |=> (nb_cnt == NB_W'(1) && !nb_flag));

  // R6
  sd_read_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && slowdma_ev_i) |=> (sd_cnt == SD_W'(1) && !sd_flag));

  // R2
  nb_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && nobuf_ev_i && nb_cnt != NB_MAX) |=> (nb_cnt == $past(nb_cnt) + NB_W'(1)));

  // R3
  sd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && slowdma_ev_i && sd_cnt != SD_MAX) |=> (sd_cnt == $past(sd_cnt) + SD_W'(1)));

  // R7
  nb_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && nobuf_ev_i && nb_cnt == NB_MAX) |=> (nb_cnt == NB_MAX && nb_flag));

  // R7
  sd_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && slowdma_ev_i && sd_cnt == SD_MAX) |=> (sd_cnt == SD_MAX && sd_flag));

  // R8
  nb_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && nb_flag) |=> nb_flag);

  // R8
  sd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && sd_flag) |=> sd_flag);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_i && !nobuf_ev_i && !slowdma_ev_i) |=> $stable(rd_data_o));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (rd_data_o == '0));

endmodule

bind dfc_status_reg dfc_status_reg_chk #(.NB_W(NB_W), .SD_W(SD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .nobuf_ev_i   (nobuf_ev_i),
  .slowdma_ev_i (slowdma_ev_i),
  .rd_i         (rd_i),
  .rd_data_o    (rd_data_o)
);

// File: tb/dfc_status_reg_tb.sv
module dfc_status_reg_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;
  localparam int NVEC       = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nobuf_ev_i = 1'b0;
  logic        slowdma_ev_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [31:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dfc_status_reg u_dut (
    .clk          (clk),
    .rst          (rst),
    .nobuf_ev_i   (nobuf_ev_i),
    .slowdma_ev_i (slowdma_ev_i),
    .rd_i         (rd_i),
    .rd_data_o    (rd_data_o)
  );

  // Row: {nobuf, slowdma, read, word expected after the edge}.
  // Layout (R1): [31] nobuf flag, [30:17] nobuf count, [16] slowdma flag, [15:0] slowdma count.
  localparam logic [34:0] VEC [NVEC] = '{
    {3'b100, 32'h0002_0000},  // R2 nobuf 1
    {3'b010, 32'h0002_0001},  // R3 slowdma 1
    {3'b110, 32'h0004_0002},  // R4 both -> 2,2
    {3'b000, 32'h0004_0002},  // R10 hold
    {3'b001, 32'h0000_0000},  // R5 read clears
    {3'b101, 32'h0002_0000},  // R6 nobuf with read
    {3'b011, 32'h0000_0001},  // R6 slowdma with read
    {3'b110, 32'h0002_0002},  // R4 both
    {3'b111, 32'h0002_0001},  // R6 both with read
    {3'b001, 32'h0000_0000}   // R5 read clears
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // Drive at falling edge, let one rising edge pass, return at next falling edge.
  task automatic step(input logic nb, input logic sd, input logic rd);
    nobuf_ev_i   = nb;
    slowdma_ev_i = sd;
    rd_i         = rd;
    @(negedge clk);
    nobuf_ev_i   = 1'b0;
    slowdma_ev_i = 1'b0;
    rd_i         = 1'b0;
  endtask

  initial begin
    logic [31:0] prev;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset state", rd_data_o, 32'h0);

    prev = 32'h0;
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][32]) chk("R5 read returns pre-edge value", rd_data_o, prev);
      step(VEC[i][34], VEC[i][33], VEC[i][32]);
      chk($sformatf("R1 vector %0d", i), rd_data_o, VEC[i][31:0]);
      prev = VEC[i][31:0];
    end

    // R8: both counters step to the nobuf maximum, no flag yet
    for (int i = 0; i < 16383; i++) step(1'b1, 1'b1, 1'b0);
    chk("R8 nobuf at max, flag clear", rd_data_o, {1'b0, 14'h3FFF, 1'b0, 16'h3FFF});
    // R7: one more nobuf event saturates and flags
    step(1'b1, 1'b1, 1'b0);
    chk("R7 nobuf saturates and flags", rd_data_o, {1'b0, 14'h3FFF, 1'b0, 16'h4000} | 32'h8000_0000);
    for (int i = 0; i < 49151; i++) step(1'b0, 1'b1, 1'b0);
    chk("R8 slowdma at max, nobuf flag sticky", rd_data_o, 32'hFFFE_FFFF);
    step(1'b0, 1'b1, 1'b0);
    chk("R7 slowdma saturates and flags", rd_data_o, 32'hFFFF_FFFF);
    step(1'b1, 1'b1, 1'b0);
    chk("R7 events beyond max held", rd_data_o, 32'hFFFF_FFFF);
    step(1'b0, 1'b0, 1'b0);
    chk("R10 idle holds saturated word", rd_data_o, 32'hFFFF_FFFF);
    chk("R5 read returns saturated word", rd_data_o, 32'hFFFF_FFFF);
    step(1'b0, 1'b0, 1'b1);
    chk("R5 read clears flags and counts", rd_data_o, 32'h0);

    // R9: reset in the middle of activity
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk("R2 counts before reset", rd_data_o, 32'h0004_0001);
    rst = 1'b1;
    step(1'b1, 1'b1, 1'b0);
    rst = 1'b0;
    chk("R9 reset clears over events", rd_data_o, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule